// File: doc/BRIEF.md
# Host Bus Register File with Gated RAM Window

This block is a slave on a 16-bit, word-addressed, asynchronous host bus driven by a microcontroller. The chip-select, read and write strobes are active-low and arrive with no relation to the local clock. The block brings them into the clock domain through flip-flop synchronisers and turns each strobe assertion into a single internal read or write event. Address and write data are assumed stable for the whole time a strobe is asserted.

Behind the decode there are two registers and a window onto an on-chip RAM. The control register holds the window enable in bit 0. The LED register drives an LED output from its bit 0. After reset the window is closed. A closed window reads back as all ones and ignores writes. Once firmware sets the enable bit, the RAM behaves as ordinary read/write memory. After reset it holds zeros, because a clearing sweep runs before the window can be opened.

Top module: `hostbus_regfile`

## Requirements
- R1: After reset, bus_rdata is 0x0000, led_out is 0, the control and LED registers are 0x0000, and the RAM window is closed.
- R2: Each strobe passes through two synchronising flip-flops. A write (cs_n and wr_n both low) takes effect on the third rising clock edge after both are first seen low. It is committed exactly once, however long the strobes stay asserted.
- R3: The control register is at word address 0x00. All 16 bits can be written and read back, and bit 0 is the RAM window enable.
- R4: The LED register is at word address 0x01. All 16 bits can be read back, and bit 0 drives led_out. led_out changes only as a result of a committed write.
- R5: The RAM window spans word addresses 0x40 to 0x7F. While the window is closed, every read in that range returns 0xFFFF.
- R6: While the window is closed, writes into the RAM range are dropped and leave the RAM contents unchanged.
- R7: While the window is open, a word written to the RAM is retained and read back unchanged. It survives the window being closed and opened again.
- R8: RAM contents are zero after reset. A sweep clears all 64 words in the first 64 cycles after reset, and the window stays closed until the sweep is done.
- R9: A read (cs_n and rd_n both low) loads bus_rdata on the third rising clock edge after both are first seen low. bus_rdata then holds that value while the strobes stay active and until the next read.
- R10: Addresses outside 0x00, 0x01 and the RAM window read as 0x0000, and writes to them change nothing.
- R11: Read or write strobes asserted while cs_n is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs_n | input | 1 | Host chip select, active low, asynchronous |
| bus_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_addr | input | 8 | Word address, stable while a strobe is asserted |
| bus_wdata | input | 16 | Write data, stable while the write strobe is asserted |
| bus_rdata | output | 16 | Registered read data |
| led_out | output | 1 | LED drive, bit 0 of the LED register |

## Verification
Some properties are checked by assertions on every cycle:
- each write produces at most one commit pulse;
- bus_rdata and led_out change only after a read or write event;
- a control-register write loads the bus data;
- a read of the closed window yields all ones;
- the clearing sweep walks forward and, once finished, stays finished.

Other behaviours need the bench's scenarios. These are the exact three-edge latency, writes that are dropped while the window is closed but show up as zeros once it opens, retention across closing and reopening the window, unmapped addresses, and strobes without chip select. The bench shows them by comparing the ports against its behavioural model on every clock.

// File: rtl/hbr_pkg.sv
// Shared definitions for the host bus register file.
// Assumes a word-addressed bus; the offsets below are word offsets.
package hbr_pkg;

    // Which target a bus address selects
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LED  = 2'd1,
        SEL_RAM  = 2'd2,
        SEL_NONE = 2'd3
    } hbr_sel_e;

    localparam int CTRL_OFS    = 0;  // control register word offset
    localparam int LED_OFS     = 1;  // LED register word offset
    localparam int CTRL_EN_BIT = 0;  // window enable bit in control
    localparam int LED_BIT     = 0;  // LED drive bit in LED register

endpackage

// File: rtl/hbr_sync.sv
// Multi-stage flip-flop synchroniser for a vector of independent
// asynchronous levels. Assumes each bit is a slow level (a bus strobe),
// so bits are not required to cross together.
module hbr_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] r;
            // single capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] r;
            // shift the input through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) r <= {STAGES{RST_VAL}};
                else        r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hbr_strobe_ctl.sv
// Turns synchronised, active-high strobe levels into one-cycle read and
// write event pulses. Assumes the inputs already come from a synchroniser.
module hbr_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic rd_act,
    input  logic wr_act,
    output logic rd_pulse,
    output logic wr_pulse
);

    logic rd_lvl, wr_lvl;
    logic rd_prev, wr_prev;

    assign rd_lvl = cs_act & rd_act;
    assign wr_lvl = cs_act & wr_act;

    // remember last qualified levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_lvl;
            wr_prev <= wr_lvl;
        end
    end

    assign rd_pulse = rd_lvl & ~rd_prev;
    assign wr_pulse = wr_lvl & ~wr_prev;

    // a held write strobe commits only once
    assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // a held read strobe captures only once
    assert_single_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

endmodule

// File: rtl/hbr_ram.sv
// Single-port-write, registered-read RAM with a post-reset clearing sweep.
// Assumes the array has no reset of its own; the sweep writes zero to every
// word and raises ready when done. External writes are ignored until then.
module hbr_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     clr_cnt;
    logic              port_we;
    logic [AW-1:0]     port_addr;
    logic [DATA_W-1:0] port_data;

    // sweep counter and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt <= '0;
            ready   <= 1'b0;
        end else if (!ready) begin
            clr_cnt <= clr_cnt + AW'(1);
            if (clr_cnt == AW'(DEPTH - 1)) ready <= 1'b1;
        end
    end

    // write port is owned by the sweep until it finishes
    always_comb begin
        if (!ready) begin
            port_we   = rst_n;
            port_addr = clr_cnt;
            port_data = '0;
        end else begin
            port_we   = we;
            port_addr = waddr;
            port_data = wdata;
        end
    end

    // array write
    always_ff @(posedge clk) begin
        if (port_we) mem[port_addr] <= port_data;
    end

    // registered read
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

    // sweep advances one word per cycle until done
    assert_clear_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready || clr_cnt == $past(clr_cnt) + AW'(1)));

    // once cleared, the RAM stays available
    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/hbr_regs.sv
// Address decode, control and LED registers, window gating and the read
// data capture register. Assumes addr and wdata are stable around each
// event pulse and that ram_q reflects addr from the previous cycle.
module hbr_regs
    import hbr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int RAM_BASE  = 'h40,
    parameter int RAM_DEPTH = 64,
    parameter int RAM_AW    = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ram_q,
    input  logic              ram_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              led,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_idx
);

    localparam logic [ADDR_W:0] RAM_LO = (ADDR_W + 1)'(RAM_BASE);
    localparam logic [ADDR_W:0] RAM_HI = (ADDR_W + 1)'(RAM_BASE + RAM_DEPTH);

    hbr_sel_e          sel;
    logic              in_ram;
    logic              win_open;
    logic [ADDR_W-1:0] ram_ofs;
    logic [DATA_W-1:0] ctrl_reg;
    logic [DATA_W-1:0] led_reg;
    logic [DATA_W-1:0] rd_mux;

    assign in_ram  = ({1'b0, addr} >= RAM_LO) && ({1'b0, addr} < RAM_HI);
    assign ram_ofs = addr - ADDR_W'(RAM_BASE);
    assign ram_idx = ram_ofs[RAM_AW-1:0];

    // address decode to a target
    always_comb begin
        if (addr == ADDR_W'(CTRL_OFS))     sel = SEL_CTRL;
        else if (addr == ADDR_W'(LED_OFS)) sel = SEL_LED;
        else if (in_ram)                   sel = SEL_RAM;
        else                               sel = SEL_NONE;
    end

    assign win_open = ctrl_reg[CTRL_EN_BIT] & ram_ready;
    assign ram_we   = wr_pulse & (sel == SEL_RAM) & win_open;
    assign led      = led_reg[LED_BIT];

    // register writes on commit pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_reg <= '0;
            led_reg  <= '0;
        end else if (wr_pulse) begin
            case (sel)
                SEL_CTRL: ctrl_reg <= wdata;
                SEL_LED:  led_reg  <= wdata;
                default:  ;
            endcase
        end
    end

    // read source selection, closed window reads as all ones
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = ctrl_reg;
            SEL_LED:  rd_mux = led_reg;
            SEL_RAM:  rd_mux = win_open ? ram_q : '1;
            default:  rd_mux = '0;
        endcase
    end

    // read data capture, held between read events
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (rd_pulse) rdata <= rd_mux;
    end

    // bus read data only moves on a read event
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pulse |=> $stable(rdata));

    // closed window returns all ones
    assert_closed_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && sel == SEL_RAM && !win_open) |=> (rdata == '1));

    // LED only moves on a write event
    assert_led_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(led));

    // control write loads the bus data
    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && sel == SEL_CTRL) |=> (ctrl_reg == $past(wdata)));

    // nothing reaches the RAM while the window is closed
    assert_closed_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && sel == SEL_RAM && !ctrl_reg[CTRL_EN_BIT]) |-> !ram_we);

endmodule

// File: rtl/hostbus_regfile.sv
// Host bus slave: synchronises the asynchronous active-low strobes, turns
// them into event pulses, and serves the register file and gated RAM window.
// Assumes address and write data are stable while a strobe is asserted.
module hostbus_regfile #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int RAM_BASE    = 'h40,
    parameter int RAM_DEPTH   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              led_out
);

    localparam int RAM_AW = $clog2(RAM_DEPTH);

    logic [2:0]        strobe_n_sync;
    logic              rd_pulse, wr_pulse;
    logic              ram_we, ram_ready;
    logic [RAM_AW-1:0] ram_idx;
    logic [DATA_W-1:0] ram_q;

    hbr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b111)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_cs_n, bus_rd_n, bus_wr_n}),
        .q     (strobe_n_sync)
    );

    hbr_strobe_ctl strobe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (~strobe_n_sync[2]),
        .rd_act   (~strobe_n_sync[1]),
        .wr_act   (~strobe_n_sync[0]),
        .rd_pulse (rd_pulse),
        .wr_pulse (wr_pulse)
    );

    hbr_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .RAM_BASE  (RAM_BASE),
        .RAM_DEPTH (RAM_DEPTH),
        .RAM_AW    (RAM_AW)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pulse  (rd_pulse),
        .wr_pulse  (wr_pulse),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ram_q     (ram_q),
        .ram_ready (ram_ready),
        .rdata     (bus_rdata),
        .led       (led_out),
        .ram_we    (ram_we),
        .ram_idx   (ram_idx)
    );

    hbr_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (RAM_DEPTH),
        .AW     (RAM_AW)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_idx),
        .wdata (bus_wdata),
        .raddr (ram_idx),
        .rdata (ram_q),
        .ready (ram_ready)
    );

    // strobes without chip select never raise an event
    assert_cs_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n_sync[2] |-> !(rd_pulse || wr_pulse));

endmodule

// File: tb/hostbus_regfile_tb.sv
// Bench for hostbus_regfile: behavioural reference model compared each
// clock, plus directed checks with hand-computed expected values.
module hostbus_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        led;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit cmp_on   = 1'b0;
    bit done     = 1'b0;

    // model state
    logic [15:0] m_ctrl, m_led, m_rdata;
    logic [15:0] m_mem [int];
    int          wr_age, rd_age;

    always #10 clk = ~clk;

    hostbus_regfile dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs_n  (cs_n),
        .bus_rd_n  (rd_n),
        .bus_wr_n  (wr_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .led_out   (led)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return m_ctrl;
        if (a == 8'h01) return m_led;
        if (a >= 8'h40 && a < 8'h80) begin
            if (!m_ctrl[0]) return 16'hFFFF;
            return m_mem.exists(int'(a)) ? m_mem[int'(a)] : 16'h0000;
        end
        return 16'h0000;
    endfunction

    // reference model: events land on the third edge of an active strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_led = '0; m_rdata = '0;
            m_mem.delete();
            wr_age = 0; rd_age = 0;
        end else begin
            if (!cs_n && !wr_n) wr_age++; else wr_age = 0;
            if (!cs_n && !rd_n) rd_age++; else rd_age = 0;
            if (rd_age == 3) m_rdata = model_read(addr);
            if (wr_age == 3) begin
                if (addr == 8'h00)      m_ctrl = wdata;
                else if (addr == 8'h01) m_led  = wdata;
                else if (addr >= 8'h40 && addr < 8'h80 && m_ctrl[0])
                    m_mem[int'(addr)] = wdata;
            end
        end
    end

    // per-clock comparison (R9 read data, R4 LED)
    always @(negedge clk) begin
        if (cmp_on) begin
            check(rdata === m_rdata, "R9 model rdata", rdata, m_rdata);
            check(led === m_led[0], "R4 model led", {15'd0, led}, {15'd0, m_led[0]});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input int hold);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        idle(hold);
        cs_n = 1'b1; wr_n = 1'b1;
        idle(4);
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        idle(5);
        check(rdata === exp, tag, rdata, exp);
        cs_n = 1'b1; rd_n = 1'b1;
        idle(4);
    endtask

    initial begin
        idle(3);
        cmp_on = 1'b1;
        // R1 reset state
        check(rdata === 16'h0000, "R1 reset rdata", rdata, 16'h0000);
        check(led === 1'b0, "R1 reset led", {15'd0, led}, 16'h0000);
        @(negedge clk) rst_n = 1'b1;
        idle(100);

        bus_read(8'h00, 16'h0000, "R1 ctrl after reset");
        bus_read(8'h01, 16'h0000, "R1 led reg after reset");
        bus_read(8'h40, 16'hFFFF, "R5 closed window low end");
        bus_read(8'h7F, 16'hFFFF, "R5 closed window high end");

        // R6 write while closed
        bus_write(8'h45, 16'h1234, 5);

        // R3 control read-back with enable clear
        bus_write(8'h00, 16'hA5A4, 5);
        bus_read(8'h00, 16'hA5A4, "R3 ctrl readback");
        bus_read(8'h45, 16'hFFFF, "R5 still closed with bit0 clear");

        // R4 LED register
        bus_write(8'h01, 16'h0001, 5);
        check(led === 1'b1, "R4 led on", {15'd0, led}, 16'h0001);
        bus_read(8'h01, 16'h0001, "R4 led readback");
        bus_write(8'h01, 16'hFFFE, 5);
        check(led === 1'b0, "R4 led off bit0 clear", {15'd0, led}, 16'h0000);

        // R2 latency: third edge after assertion, single commit on long hold
        @(negedge clk);
        addr = 8'h01; wdata = 16'h0001; cs_n = 1'b0; wr_n = 1'b0;
        idle(2);
        check(led === 1'b0, "R2 not yet committed after two edges", {15'd0, led}, 16'h0000);
        idle(1);
        check(led === 1'b1, "R2 committed on third edge", {15'd0, led}, 16'h0001);
        wdata = 16'h0000;
        idle(20);
        check(led === 1'b1, "R2 single commit under long hold", {15'd0, led}, 16'h0001);
        cs_n = 1'b1; wr_n = 1'b1;
        idle(4);

        // open the window: dropped write and cleared RAM read as zero
        bus_write(8'h00, 16'h0001, 5);
        bus_read(8'h45, 16'h0000, "R6 dropped write left zero");
        bus_read(8'h7F, 16'h0000, "R8 cleared top word");

        // R7 write and read back
        bus_write(8'h40, 16'hBEEF, 5);
        bus_write(8'h7F, 16'h5A5A, 5);
        bus_read(8'h40, 16'hBEEF, "R7 low word retained");
        bus_read(8'h7F, 16'h5A5A, "R7 high word retained");
        bus_read(8'h41, 16'h0000, "R8 unwritten neighbour zero");

        // R9 hold after read ends
        idle(10);
        check(rdata === 16'h0000, "R9 rdata held after read", rdata, 16'h0000);

        // R10 unmapped addresses
        bus_write(8'h10, 16'hFFFF, 5);
        bus_write(8'h80, 16'hFFFF, 5);
        bus_read(8'h10, 16'h0000, "R10 unmapped low");
        bus_read(8'h80, 16'h0000, "R10 just past window");
        bus_read(8'h00, 16'h0001, "R10 ctrl untouched");
        bus_read(8'h01, 16'h0001, "R10 led reg untouched");

        // R11 strobes without chip select
        @(negedge clk);
        addr = 8'h01; wdata = 16'h0000; wr_n = 1'b0;
        idle(6);
        wr_n = 1'b1;
        idle(4);
        check(led === 1'b1, "R11 write without cs ignored", {15'd0, led}, 16'h0001);
        @(negedge clk);
        addr = 8'h40; rd_n = 1'b0;
        idle(6);
        check(rdata === 16'h0001, "R11 read without cs ignored", rdata, 16'h0001);
        rd_n = 1'b1;
        idle(4);

        // R7 retention across close and reopen
        bus_write(8'h00, 16'h0000, 5);
        bus_read(8'h40, 16'hFFFF, "R5 closed again");
        bus_write(8'h40, 16'h0000, 5);
        bus_write(8'h00, 16'h0001, 5);
        bus_read(8'h40, 16'hBEEF, "R7 retained after reopen");

        idle(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule